// File: doc/BRIEF.md
# Condition On/Off Delay Qualifier

This block qualifies one boolean condition in time. The raw condition has to stay true for longer than a programmable on-delay before the qualified pre-output rises. It has to stay false for longer than a programmable off-delay before the pre-output falls. Both delays are unsigned counts of scan ticks. Time advances only on a one-cycle scan-tick strobe, and every register holds its value between strobes.

A read-error flag marks a scan in which the condition could not be fetched. On such a scan a 2-bit option either forces the pre-output low, forces it high or keeps it, and a status bit reports the output as bad. An abort mode overrides the option: the scan then leaves the outputs and their status untouched. A per-condition disable gates the final output. When the override parameter is set, an override bit makes the disable ineffective. An elapsed-time counter reports time in one of two ways, selected by whether the off-delay is zero. The parent logic places one instance per condition.

Top module: `cdq_qualifier`

## Requirements
- R1: While `rst_n` is low, `pre_q`, `pre_bad` and `gated_q` are cleared on the clock edge, `elapsed` becomes 0 and all internal run counters clear.
- R2: On a clock edge with `tick` low, no output and no internal counter changes, whatever the other inputs do.
- R3: On a clean tick (`tick`=1, `rd_err`=0) with `pre_q` low, `pre_q` rises on the tick where the count of consecutive clean true ticks, this tick included, exceeds `on_dly`. A false clean tick restarts that count.
- R4: On a clean tick with `pre_q` high, `pre_q` falls on the tick where the count of consecutive clean false ticks, this tick included, exceeds `off_dly`. A true clean tick restarts that count.
- R5: With `off_dly`=0, on clean ticks `elapsed` goes to 0 when `pre_q` falls. Otherwise it goes to 1 on a tick where the condition is true after a false tick. It increments on a tick where the condition is true after a true tick, and it holds when the condition is false.
- R6: With `off_dly`≠0, on clean ticks `elapsed` goes to 0 when `pre_q` rises. Otherwise it goes to 1 on a tick where the condition is false after a true tick. It increments on a tick where the condition is false after a false tick, and it holds when the condition is true.
- R7: The run counters and `elapsed` saturate at 2^W−1 (65535 by default) instead of wrapping. With `on_dly`=65535, `pre_q` rises on the 65536th consecutive true tick.
- R8: On a tick with `rd_err`=1 and `abort_on_err`=0, `pre_bad` becomes 1 and `err_opt` sets `pre_q`: code 0 forces it low, code 1 forces it high, and codes 2 and 3 keep it. Both run counters clear and `elapsed` holds. The next clean tick returns `pre_bad` to 0.
- R9: On a tick with `rd_err`=1 and `abort_on_err`=1, `pre_q`, `gated_q`, `pre_bad`, `elapsed` and the run counters all keep their values.
- R10: `pre_q` does not depend on `dis`. On each tick that updates `pre_q`, `gated_q` takes the new `pre_q` value, or 0 when `dis`=1 and the override does not apply.
- R11: With parameter `HAS_OVR`=1 (the default), `dis_ovr`=1 makes `dis` have no effect on `gated_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Scan-tick strobe, one cycle per scan |
| cond_in | input | 1 | Raw condition value for this scan |
| rd_err | input | 1 | The condition could not be read this scan |
| abort_on_err | input | 1 | A read error leaves the scan with no effect |
| err_opt | input | 2 | Pre-output on read error: 0 low, 1 high, 2/3 keep |
| on_dly | input | W | On-delay in ticks |
| off_dly | input | W | Off-delay in ticks; zero selects elapsed-since-true |
| dis | input | 1 | Condition disable for the gated output |
| dis_ovr | input | 1 | Makes `dis` ineffective (interlock use) |
| pre_q | output | 1 | Qualified pre-output |
| pre_bad | output | 1 | Pre-output status: 1 means bad (read error) |
| gated_q | output | 1 | Pre-output after the disable gate |
| elapsed | output | W | Elapsed-tick counter |

## Verification
Directed runs first cover short pulses that end before the on-delay, and false gaps that close before the off-delay. These separate a restarting run counter from one that only pauses. They also show that the `elapsed` reference point changes with `off_dly` being zero or not. A single long run with the maximum on-delay tells saturation apart from wrap-around at the counter limit. Constrained-random ticks then bias the condition to dwell, mix in read errors with random options and abort settings, toggle the disable and the override, and insert idle gaps. These patterns separate the error force and keep codes, separate an aborted scan from an erroring one, and show that nothing moves between ticks.

// File: rtl/cdq_pkg.sv
// Package: shared types and helpers for the condition delay qualifier.
// Assumes: err_opt is a 2-bit code; codes 2 and 3 both keep the value.
package cdq_pkg;

    typedef enum logic [1:0] {
        ERR_FORCE_LOW  = 2'd0,
        ERR_FORCE_HIGH = 2'd1,
        ERR_KEEP       = 2'd2,
        ERR_KEEP_ALT   = 2'd3
    } err_opt_e;

    // Level the pre-output takes on a read-error scan.
    function automatic logic err_level(input err_opt_e opt, input logic last);
        case (opt)
            ERR_FORCE_LOW:  return 1'b0;
            ERR_FORCE_HIGH: return 1'b1;
            default:        return last;
        endcase
    endfunction

endpackage

// File: rtl/cdq_run_timer.sv
// Module: saturating run-length counter for one qualification direction.
// Counts consecutive advancing ticks while 'arm' is high. It flags 'expired'
// on the tick where the run, this tick included, exceeds 'limit'. The run
// restarts on expiry or on any advancing tick without 'arm'.
// Assumes: 'adv' and 'clr' are never high together.
module cdq_run_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         clr,
    input  logic         arm,
    input  logic [W-1:0] limit,
    output logic         expired
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt;
    logic [W:0]   run_len;

    // Run length including the present tick, one bit wider than the counter.
    assign run_len = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
    assign expired = adv && arm && (run_len > {1'b0, limit});

    // Advance, restart or clear the run counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (adv) begin
            if (arm && !expired)
                cnt <= (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
            else
                cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/cdq_elapsed.sv
// Module: elapsed-tick counter whose reference point depends on the
// off-delay. With a zero off-delay it counts from the condition going true
// and clears when the pre-output falls. With a non-zero off-delay it counts
// from the condition going false and clears when the pre-output rises.
// Assumes: 'rise' and 'fall' come from the same clean tick as 'adv'.
module cdq_elapsed #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         off_mode,
    input  logic         cond,
    input  logic         rise,
    input  logic         fall,
    output logic [W-1:0] elapsed
);
    localparam logic [W-1:0] EL_MAX = '1;
    localparam logic [W-1:0] EL_ONE = W'(1);

    logic         cond_prev;
    logic [W-1:0] el_step;
    logic [W-1:0] el_nxt;

    assign el_step = (elapsed == EL_MAX) ? EL_MAX : elapsed + 1'b1;

    // Select the next elapsed value for the active reference mode.
    always_comb begin
        el_nxt = elapsed;
        if (!off_mode) begin
            if (fall)
                el_nxt = '0;
            else if (cond)
                el_nxt = cond_prev ? el_step : EL_ONE;
        end else begin
            if (rise)
                el_nxt = '0;
            else if (!cond)
                el_nxt = cond_prev ? EL_ONE : el_step;
        end
    end

    // Register the counter and the condition seen on the last clean tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed   <= '0;
            cond_prev <= 1'b0;
        end else if (adv) begin
            elapsed   <= el_nxt;
            cond_prev <= cond;
        end
    end

endmodule

// File: rtl/cdq_out_stage.sv
// Module: output registers for the pre-output, its status and the gated
// output. Clean ticks apply rise/fall and mark the status good. Error ticks
// apply the error option and mark it bad. Every other cycle holds.
// Assumes: 'normal' and 'err_act' are mutually exclusive.
module cdq_out_stage
    import cdq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       normal,
    input  logic       err_act,
    input  logic       rise,
    input  logic       fall,
    input  logic [1:0] err_opt,
    input  logic       out_en,
    output logic       pre_q,
    output logic       pre_bad,
    output logic       gated_q
);
    logic pre_nxt;

    // Next pre-output value for clean and error scans.
    always_comb begin
        pre_nxt = pre_q;
        if (normal) begin
            if (rise)
                pre_nxt = 1'b1;
            else if (fall)
                pre_nxt = 1'b0;
        end else if (err_act) begin
            pre_nxt = err_level(err_opt_e'(err_opt), pre_q);
        end
    end

    // Update outputs only on scans that are allowed to change them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q   <= 1'b0;
            pre_bad <= 1'b0;
            gated_q <= 1'b0;
        end else if (normal || err_act) begin
            pre_q   <= pre_nxt;
            pre_bad <= err_act;
            gated_q <= pre_nxt && out_en;
        end
    end

endmodule

// File: rtl/cdq_qualifier.sv
// Module: top of the condition on/off delay qualifier. It classifies each
// cycle as clean tick, error tick or hold. It runs the on and off run timers,
// the elapsed counter and the output stage.
// Assumes: 'tick' is a single-cycle strobe; delays are tick counts.
module cdq_qualifier #(
    parameter int W       = 16,
    parameter bit HAS_OVR = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cond_in,
    input  logic         rd_err,
    input  logic         abort_on_err,
    input  logic [1:0]   err_opt,
    input  logic [W-1:0] on_dly,
    input  logic [W-1:0] off_dly,
    input  logic         dis,
    input  logic         dis_ovr,
    output logic         pre_q,
    output logic         pre_bad,
    output logic         gated_q,
    output logic [W-1:0] elapsed
);
    logic normal;
    logic err_act;
    logic rise;
    logic fall;
    logic out_en;
    logic off_mode;

    assign normal   = tick && !rd_err;
    assign err_act  = tick && rd_err && !abort_on_err;
    assign off_mode = |off_dly;

    // Disable gate, with or without the override input.
    generate
        if (HAS_OVR) begin : g_ovr
            assign out_en = !dis || dis_ovr;
        end else begin : g_no_ovr
            assign out_en = !dis;
        end
    endgenerate

    cdq_run_timer #(.W(W)) u_on_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (normal),
        .clr     (err_act),
        .arm     (cond_in && !pre_q),
        .limit   (on_dly),
        .expired (rise)
    );

    cdq_run_timer #(.W(W)) u_off_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (normal),
        .clr     (err_act),
        .arm     (!cond_in && pre_q),
        .limit   (off_dly),
        .expired (fall)
    );

    cdq_elapsed #(.W(W)) u_elapsed (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (normal),
        .off_mode (off_mode),
        .cond     (cond_in),
        .rise     (rise),
        .fall     (fall),
        .elapsed  (elapsed)
    );

    cdq_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .normal  (normal),
        .err_act (err_act),
        .rise    (rise),
        .fall    (fall),
        .err_opt (err_opt),
        .out_en  (out_en),
        .pre_q   (pre_q),
        .pre_bad (pre_bad),
        .gated_q (gated_q)
    );

endmodule

// File: rtl/cdq_qualifier_chk.sv
// Module: assertion checker bound to cdq_qualifier; watches only its ports.
module cdq_qualifier_chk #(
    parameter int W       = 16,
    parameter bit HAS_OVR = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         cond_in,
    input logic         rd_err,
    input logic         abort_on_err,
    input logic [1:0]   err_opt,
    input logic [W-1:0] on_dly,
    input logic [W-1:0] off_dly,
    input logic         dis,
    input logic         dis_ovr,
    input logic         pre_q,
    input logic         pre_bad,
    input logic         gated_q,
    input logic [W-1:0] elapsed
);
    // R1: reset clears the outputs on the next edge.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!pre_q && !pre_bad && !gated_q && elapsed == '0));

    // R2: nothing moves without a tick.
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !tick) |=> ($stable(pre_q) && $stable(pre_bad)
                              && $stable(gated_q) && $stable(elapsed)));

    // R3: a false clean tick never raises the pre-output.
    p_no_rise_false_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !rd_err && !pre_q && !cond_in) |=> !pre_q);

    // R4: a true clean tick never lowers the pre-output.
    p_no_fall_true_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !rd_err && pre_q && cond_in) |=> pre_q);

    // R8: an error tick flags the status bad.
    p_err_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rd_err && !abort_on_err) |=> pre_bad);

    // R8: error codes 0 and 1 force the level.
    p_err_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rd_err && !abort_on_err && err_opt[1] == 1'b0)
            |=> (pre_q == $past(err_opt[0])));

    // R8: a clean tick returns the status to good.
    p_clean_good_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !rd_err) |=> !pre_bad);

    // R9: an aborted scan keeps everything.
    p_abort_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rd_err && abort_on_err) |=> ($stable(pre_q) && $stable(pre_bad)
                                              && $stable(gated_q) && $stable(elapsed)));

    // R10: the gated output never exceeds the pre-output.
    p_gate_subset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gated_q |-> pre_q);

    // R10/R11: a disable without an effective override drives the gate low.
    p_disable_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(rd_err && abort_on_err) && dis && !(HAS_OVR && dis_ovr))
            |=> !gated_q);

    // R11: with the override in effect, the gate follows the pre-output.
    p_ovr_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_OVR && tick && !(rd_err && abort_on_err) && dis_ovr)
            |=> (gated_q == pre_q));

endmodule

bind cdq_qualifier cdq_qualifier_chk #(.W(W), .HAS_OVR(HAS_OVR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .cond_in      (cond_in),
    .rd_err       (rd_err),
    .abort_on_err (abort_on_err),
    .err_opt      (err_opt),
    .on_dly       (on_dly),
    .off_dly      (off_dly),
    .dis          (dis),
    .dis_ovr      (dis_ovr),
    .pre_q        (pre_q),
    .pre_bad      (pre_bad),
    .gated_q      (gated_q),
    .elapsed      (elapsed)
);

// File: tb/cdq_qualifier_tb.sv
`timescale 1ns/1ps
module cdq_qualifier_tb;
    localparam int W = 16;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         cond_in = 1'b0;
    logic         rd_err = 1'b0;
    logic         abort_on_err = 1'b0;
    logic [1:0]   err_opt = 2'd0;
    logic [W-1:0] on_dly = '0;
    logic [W-1:0] off_dly = '0;
    logic         dis = 1'b0;
    logic         dis_ovr = 1'b0;
    logic         pre_q, pre_bad, gated_q;
    logic [W-1:0] elapsed;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference state, advanced from the requirements.
    int m_on, m_off, m_el;
    bit m_pre, m_bad, m_gated, m_prev;

    always #2.5 clk = ~clk;

    cdq_qualifier #(.W(W), .HAS_OVR(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cond_in(cond_in),
        .rd_err(rd_err), .abort_on_err(abort_on_err), .err_opt(err_opt),
        .on_dly(on_dly), .off_dly(off_dly), .dis(dis), .dis_ovr(dis_ovr),
        .pre_q(pre_q), .pre_bad(pre_bad), .gated_q(gated_q), .elapsed(elapsed)
    );

    function automatic int sat(input int v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    function automatic bit err_val(input logic [1:0] opt, input bit last);
        if (opt == 2'd0) return 1'b0;
        if (opt == 2'd1) return 1'b1;
        return last;
    endfunction

    task automatic m_reset();
        m_on = 0; m_off = 0; m_el = 0;
        m_pre = 0; m_bad = 0; m_gated = 0; m_prev = 0;
    endtask

    // One tick of the reference, from the current inputs.
    task automatic m_step();
        bit rise, fall, nxt;
        if (rd_err && abort_on_err) return;
        if (rd_err) begin
            m_on = 0; m_off = 0;
            m_pre = err_val(err_opt, m_pre);
            m_bad = 1;
            m_gated = m_pre && (!dis || dis_ovr);
            return;
        end
        rise = !m_pre && cond_in && (m_on + 1 > int'(on_dly));
        fall = m_pre && !cond_in && (m_off + 1 > int'(off_dly));
        m_on  = (!m_pre && cond_in && !rise) ? sat(m_on + 1) : 0;
        m_off = (m_pre && !cond_in && !fall) ? sat(m_off + 1) : 0;
        if (off_dly == 0) begin
            if (fall) m_el = 0;
            else if (cond_in) m_el = m_prev ? sat(m_el + 1) : 1;
        end else begin
            if (rise) m_el = 0;
            else if (!cond_in) m_el = m_prev ? 1 : sat(m_el + 1);
        end
        nxt = rise ? 1'b1 : (fall ? 1'b0 : m_pre);
        m_pre = nxt;
        m_bad = 0;
        m_gated = nxt && (!dis || dis_ovr);
        m_prev = cond_in;
    endtask

    task automatic cmp(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmp_model(input string tag);
        cmp(pre_q,   m_pre,   {tag, " pre_q"});
        cmp(pre_bad, m_bad,   {tag, " pre_bad"});
        cmp(gated_q, m_gated, {tag, " gated_q"});
        cmp(elapsed, m_el,    {tag, " elapsed"});
    endtask

    // Hold tick high for n edges with constant inputs, stepping the reference.
    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            m_step();
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic tk(input bit c, input string tag);
        cond_in = c;
        run_ticks(1);
        cmp_model(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        cmp(pre_q, 0, "R1 pre_q"); cmp(pre_bad, 0, "R1 pre_bad");
        cmp(gated_q, 0, "R1 gated_q"); cmp(elapsed, 0, "R1 elapsed");
        rst_n = 1'b1;

        // R3 / R6: on-delay 2, off-delay 3
        on_dly = 16'd2; off_dly = 16'd3;
        tk(1, "R3"); cmp(pre_q, 0, "R3 tick1");
        tk(1, "R3"); cmp(pre_q, 0, "R3 tick2");
        tk(1, "R3"); cmp(pre_q, 1, "R3 tick3"); cmp(elapsed, 0, "R6 clear on rise");
        // R4: short false gap does not drop
        tk(0, "R4"); cmp(elapsed, 1, "R6 since false");
        tk(1, "R4"); cmp(pre_q, 1, "R4 gap closed"); cmp(elapsed, 1, "R6 hold on true");
        tk(0, "R4"); tk(0, "R4"); tk(0, "R4"); cmp(pre_q, 1, "R4 three false");
        tk(0, "R4"); cmp(pre_q, 0, "R4 fourth false"); cmp(elapsed, 4, "R6 count");

        // R2: idle cycles with changed inputs
        cond_in = 1'b1; dis = 1'b1; err_opt = 2'd1; rd_err = 1'b1;
        repeat (3) @(negedge clk);
        cmp_model("R2 idle");
        rd_err = 1'b0; dis = 1'b0;

        // R5: zero delays
        on_dly = 0; off_dly = 0;
        tk(1, "R5"); cmp(pre_q, 1, "R3 zero delay"); cmp(elapsed, 1, "R5 first true");
        tk(1, "R5"); cmp(elapsed, 2, "R5 count");
        tk(0, "R5"); cmp(pre_q, 0, "R4 zero delay"); cmp(elapsed, 0, "R5 clear on fall");

        // R8: read error options
        tk(1, "R8");
        rd_err = 1; err_opt = 2'd0; tk(1, "R8");
        cmp(pre_q, 0, "R8 force low"); cmp(pre_bad, 1, "R8 bad");
        err_opt = 2'd1; tk(0, "R8"); cmp(pre_q, 1, "R8 force high");
        err_opt = 2'd2; tk(0, "R8"); cmp(pre_q, 1, "R8 keep");
        err_opt = 2'd3; tk(0, "R8"); cmp(pre_q, 1, "R8 keep alt");
        rd_err = 0; tk(0, "R8"); cmp(pre_q, 0, "R8 after error"); cmp(pre_bad, 0, "R8 good");

        // R9: abort mode
        rd_err = 1; abort_on_err = 1; err_opt = 2'd1; tk(1, "R9");
        cmp(pre_q, 0, "R9 hold pre"); cmp(pre_bad, 0, "R9 hold status");
        rd_err = 0; abort_on_err = 0;

        // R10 / R11: disable and override
        tk(1, "R10"); cmp(gated_q, 1, "R10 enabled");
        dis = 1; tk(1, "R10"); cmp(pre_q, 1, "R10 pre ignores dis"); cmp(gated_q, 0, "R10 gated low");
        dis_ovr = 1; tk(1, "R11"); cmp(gated_q, 1, "R11 override");
        dis = 0; dis_ovr = 0;

        // R7: saturation with maximum on-delay
        tk(0, "R7");
        on_dly = 16'hFFFF; off_dly = 0;
        cond_in = 1; run_ticks(65535); cmp_model("R7");
        cmp(pre_q, 0, "R7 before limit"); cmp(elapsed, MAXV, "R7 elapsed sat");
        run_ticks(1); cmp_model("R7");
        cmp(pre_q, 1, "R7 at limit"); cmp(elapsed, MAXV, "R7 elapsed held sat");

        // Random phase: R3 R4 R5 R6 R8 R9 R10 R11
        void'($urandom(32'h5EED_C0DE));
        for (int k = 0; k < 3000; k++) begin
            if (k % 40 == 0) begin
                on_dly  = 16'($urandom_range(0, 3));
                off_dly = 16'($urandom_range(0, 3));
            end
            if ($urandom_range(0, 99) < 25) cond_in = ~cond_in;
            rd_err       = ($urandom_range(0, 99) < 10);
            abort_on_err = $urandom_range(0, 1);
            err_opt      = 2'($urandom_range(0, 3));
            dis          = ($urandom_range(0, 99) < 20);
            dis_ovr      = ($urandom_range(0, 99) < 30);
            run_ticks(1);
            cmp_model(rd_err ? (abort_on_err ? "R9 rand" : "R8 rand") : "R3 R4 rand");
            if ($urandom_range(0, 3) == 0) begin
                cond_in = ~cond_in;
                repeat (2) @(negedge clk);
                cmp_model("R2 rand idle");
            end
        end

        // R1: reset again after activity
        @(negedge clk); rst_n = 0; @(negedge clk); m_reset();
        cmp_model("R1 re-reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule